// File: doc/BRIEF.md
# Whole-Group Store-and-Forward Buffer

This block sits in a valid/ready word stream and lets words through only in complete groups of a programmable size N. Every incoming word, together with one sideband bit, is written into an internal memory. The words are not visible downstream until the word carrying the input last flag arrives. At that point the length of the group is compared with N. A group of exactly N words is committed and becomes readable. A group of any other length is removed by moving the write pointer back, and no cycle is spent on it. The upstream source raises the last flag after every N words and on the final word of a burst. As a result, only a short trailing group is ever removed, and downstream always receives a whole multiple of N words.

N is written over a small settings port that carries a strobe, an 8-bit address and 32-bit data. The written value is held as a pending size. It becomes the active size only while no group is partly received, so a group is never judged against two different sizes. A flush pulse at the end of a burst discards any partial group still being collected. A clear input empties the whole buffer without a full reset.

Top module: `grp_drop_buf`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1, and the active and pending group sizes both equal `DEF_GRP`.
- R2: A group whose last-flagged word is its Nth word comes out complete and in arrival order, with each data word and its sideband bit unchanged.
- R3: A group whose last-flagged word arrives before N words is discarded. None of its words ever reach the output.
- R4: A group that reaches its last-flagged word after more than N words is discarded in the same way.
- R5: `out_valid` is never 1 for a word whose group has not yet received its last-flagged word.
- R6: Internal storage holds 2^ceil(log2(`MAX_GRP`)) words, committed or not, plus one word in the output register. With the output stalled, `in_ready` falls once that capacity is full, and no accepted word is overwritten. With N=4 and 16 words of storage, exactly 17 words are accepted.
- R7: While `flush` is 1, `in_ready` is 0. A flush removes the partial group being collected and leaves committed words untouched.
- R8: A `clear` pulse drops every stored word, committed or not. It holds `in_ready` at 0 in that cycle, makes `out_valid` 0 in the next cycle, and keeps the pending group size.
- R9: A settings write with `set_addr` equal to `CFG_ADDR` and a `set_data` value from 1 to `MAX_GRP` sets the pending size. Writes of 0, writes above `MAX_GRP` and writes to other addresses are ignored.
- R10: The pending size is copied to the active size only when no partial group is held: on an idle cycle with the group empty, on a last-flagged word, on flush or on clear. A group always uses the size that was active when its first word arrived.
- R11: While `out_valid` is 1 and `out_ready` is 0, the output word, sideband and last flag stay unchanged and `out_valid` stays 1, unless `clear` is applied.
- R12: `out_last` is 1 on the Nth word of each forwarded group and 0 on all other words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Empty the buffer and return to idle |
| flush | input | 1 | Drop the partial group being collected |
| set_stb | input | 1 | Settings write strobe |
| set_addr | input | 8 | Settings write address |
| set_data | input | 32 | Settings write data (group size) |
| in_data | input | DATA_W | Input data word |
| in_side | input | 1 | Sideband bit carried with the word |
| in_last | input | 1 | Marks the final word of a group |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when valid |
| out_data | output | DATA_W | Output data word |
| out_side | output | 1 | Sideband bit of the output word |
| out_last | output | 1 | Final word of a forwarded group |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |

## Verification
The bench mixes short, exact and over-long groups under random output back-pressure. A design that committed on any last flag would let short or long fragments through. A design that released words before their group was complete would raise `out_valid` while the reference holds nothing. Storage is filled with the output stalled and the bench counts the words accepted: a wrong full test would accept one word too many, overwriting unread data, or one too few. Size writes are placed in the middle of a group, flush pulses are placed between partial words, and a clear is issued while committed words are still waiting. A design that switched size mid-group, left flushed words behind or kept data through a clear would produce output that differs from the reference.

// File: rtl/grp_pkg.sv
// Shared definitions for the whole-group buffer.
// Assumes nothing beyond standard SystemVerilog packages.
package grp_pkg;

    // Outcome of an accepted input word for the group being collected
    typedef enum logic [1:0] {
        VERD_HOLD   = 2'd0,
        VERD_COMMIT = 2'd1,
        VERD_DROP   = 2'd2
    } grp_verdict_e;

    // A group size is legal when it lies in 1..max_size
    function automatic logic size_legal(input logic [31:0] value,
                                        input int unsigned max_size);
        return (value != 32'd0) && (value <= max_size);
    endfunction

endpackage

// File: rtl/grp_size_reg.sv
// Group size registers: a pending value written over the settings port
// and an active value used by the write side.
// Assumes load_ok is raised by the write side only while no partial
// group is held, so the active size never changes inside a group.
module grp_size_reg
    import grp_pkg::*;
#(
    parameter int unsigned MAX_GRP  = 64,
    parameter int unsigned DEF_GRP  = 4,
    parameter logic [7:0]  CFG_ADDR = 8'h10,
    parameter int unsigned CW       = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          set_stb,
    input  logic [7:0]    set_addr,
    input  logic [31:0]   set_data,
    input  logic          load_ok,
    output logic [CW-1:0] pend_n,
    output logic [CW-1:0] act_n
);

    logic set_hit;

    assign set_hit = set_stb && (set_addr == CFG_ADDR) && size_legal(set_data, MAX_GRP);

    // Pending size: takes legal writes addressed to this block
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_n <= CW'(DEF_GRP);
        end else if (set_hit) begin
            pend_n <= set_data[CW-1:0];
        end
    end

    // Active size: copied from pending at group boundaries or on clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_n <= CW'(DEF_GRP);
        end else if (clear || load_ok) begin
            act_n <= pend_n;
        end
    end

endmodule

// File: rtl/grp_ram.sv
// Simple dual-port storage with a registered read port.
// Assumes the caller never reads and writes the same slot in one cycle.
module grp_ram #(
    parameter int unsigned W  = 34,
    parameter int unsigned AW = 6
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_q
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    // Write port
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Read port: word lands in rd_q one cycle after rd_en
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_q <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/grp_wr_ctrl.sv
// Write side: counts words of the group being collected, commits the
// group when its length matches the active size and rolls the write
// pointer back otherwise. Pointers carry one extra wrap bit.
// Assumes rd_ptr never passes cmt_ptr.
module grp_wr_ctrl
    import grp_pkg::*;
#(
    parameter int unsigned AW = 6,
    parameter int unsigned CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          flush,
    input  logic          in_valid,
    input  logic          in_last,
    input  logic [CW-1:0] act_n,
    input  logic [AW:0]   rd_ptr,
    output logic          in_ready,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW:0]   wr_ptr,
    output logic [AW:0]   cmt_ptr,
    output logic [CW-1:0] grp_cnt,
    output logic          load_ok
);

    logic [AW:0]   occ;
    logic          full;
    logic          fire;
    logic [CW-1:0] cnt_next;
    grp_verdict_e  verdict;

    // Occupancy covers committed, uncommitted and unread words
    assign occ      = wr_ptr - rd_ptr;
    assign full     = occ[AW];
    assign in_ready = rst_n && !clear && !flush && !full;
    assign fire     = in_valid && in_ready;
    assign wr_en    = fire;
    assign wr_addr  = wr_ptr[AW-1:0];

    // Saturating word count so an over-long group cannot wrap to N
    assign cnt_next = (grp_cnt == {CW{1'b1}}) ? grp_cnt : grp_cnt + 1'b1;

    // Decide what the accepted word does to the group
    always_comb begin
        verdict = VERD_HOLD;
        if (fire && in_last) begin
            verdict = (cnt_next == act_n) ? VERD_COMMIT : VERD_DROP;
        end
    end

    // Size may change only while the group is empty or just closed
    assign load_ok = flush || (fire && in_last) || ((grp_cnt == '0) && !fire);

    // Pointer and count update
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr  <= '0;
            cmt_ptr <= '0;
            grp_cnt <= '0;
        end else if (flush) begin
            wr_ptr  <= cmt_ptr;
            grp_cnt <= '0;
        end else if (fire) begin
            case (verdict)
                VERD_COMMIT: begin
                    wr_ptr  <= wr_ptr + 1'b1;
                    cmt_ptr <= wr_ptr + 1'b1;
                    grp_cnt <= '0;
                end
                VERD_DROP: begin
                    wr_ptr  <= cmt_ptr;
                    grp_cnt <= '0;
                end
                default: begin
                    wr_ptr  <= wr_ptr + 1'b1;
                    grp_cnt <= cnt_next;
                end
            endcase
        end
    end

endmodule

// File: rtl/grp_rd_ctrl.sv
// Read side: fetches committed words into the output register of the
// storage and keeps them there until downstream accepts.
// Assumes the storage read data is valid one cycle after rd_en.
module grp_rd_ctrl #(
    parameter int unsigned AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [AW:0]   cmt_ptr,
    input  logic          out_ready,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic [AW:0]   rd_ptr,
    output logic          out_valid
);

    logic avail;

    assign avail   = (rd_ptr != cmt_ptr);
    assign rd_en   = rst_n && !clear && avail && (!out_valid || out_ready);
    assign rd_addr = rd_ptr[AW-1:0];

    // Read pointer and output valid flag
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rd_ptr    <= '0;
            out_valid <= 1'b0;
        end else if (rd_en) begin
            rd_ptr    <= rd_ptr + 1'b1;
            out_valid <= 1'b1;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/grp_drop_buf.sv
// Whole-group store-and-forward buffer. Words are released downstream
// only in groups whose length equals the programmed size; other groups
// are dropped by rolling back the write pointer.
// Assumes MAX_GRP >= 2; storage depth is MAX_GRP rounded up to a power of two.
module grp_drop_buf
    import grp_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned MAX_GRP  = 64,
    parameter int unsigned DEF_GRP  = 4,
    parameter logic [7:0]  CFG_ADDR = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              flush,
    input  logic              set_stb,
    input  logic [7:0]        set_addr,
    input  logic [31:0]       set_data,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_side,
    input  logic              in_last,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_side,
    output logic              out_last,
    output logic              out_valid,
    input  logic              out_ready
);

    localparam int unsigned AW = $clog2(MAX_GRP);
    localparam int unsigned CW = $clog2(MAX_GRP + 2);
    localparam int unsigned RW = DATA_W + 2;

    logic [CW-1:0] pend_n;
    logic [CW-1:0] act_n;
    logic [CW-1:0] grp_cnt;
    logic          load_ok;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [AW:0]   wr_ptr;
    logic [AW:0]   cmt_ptr;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [AW:0]   rd_ptr;
    logic [RW-1:0] ram_q;

    grp_size_reg #(
        .MAX_GRP  (MAX_GRP),
        .DEF_GRP  (DEF_GRP),
        .CFG_ADDR (CFG_ADDR),
        .CW       (CW)
    ) i_size (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .set_stb  (set_stb),
        .set_addr (set_addr),
        .set_data (set_data),
        .load_ok  (load_ok),
        .pend_n   (pend_n),
        .act_n    (act_n)
    );

    grp_wr_ctrl #(
        .AW (AW),
        .CW (CW)
    ) i_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .flush    (flush),
        .in_valid (in_valid),
        .in_last  (in_last),
        .act_n    (act_n),
        .rd_ptr   (rd_ptr),
        .in_ready (in_ready),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_ptr   (wr_ptr),
        .cmt_ptr  (cmt_ptr),
        .grp_cnt  (grp_cnt),
        .load_ok  (load_ok)
    );

    grp_ram #(
        .W  (RW),
        .AW (AW)
    ) i_ram (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data ({in_last, in_side, in_data}),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_q    (ram_q)
    );

    grp_rd_ctrl #(
        .AW (AW)
    ) i_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .cmt_ptr   (cmt_ptr),
        .out_ready (out_ready),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_ptr    (rd_ptr),
        .out_valid (out_valid)
    );

    // Unpack the stored word onto the output
    assign {out_last, out_side, out_data} = ram_q;

endmodule

// File: rtl/grp_drop_buf_chk.sv
// Property checker for the whole-group buffer, bound to its top.
// Assumes the top's internal pointer and size signal names.
module grp_drop_buf_chk #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned MAX_GRP  = 64,
    parameter logic [7:0]  CFG_ADDR = 8'h10,
    parameter int unsigned AW       = 6,
    parameter int unsigned CW       = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear,
    input logic              flush,
    input logic              set_stb,
    input logic [7:0]        set_addr,
    input logic [31:0]       set_data,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_last,
    input logic [DATA_W-1:0] out_data,
    input logic              out_side,
    input logic              out_last,
    input logic              out_valid,
    input logic              out_ready,
    input logic [AW:0]       wr_ptr,
    input logic [AW:0]       cmt_ptr,
    input logic [AW:0]       rd_ptr,
    input logic [CW-1:0]     grp_cnt,
    input logic [CW-1:0]     act_n,
    input logic [CW-1:0]     pend_n
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [AW:0] occ_all;
    logic [AW:0] occ_cmt;
    logic        bad_size;

    assign occ_all  = wr_ptr - rd_ptr;
    assign occ_cmt  = cmt_ptr - rd_ptr;
    assign bad_size = (set_data == 32'd0) || (set_data > MAX_GRP);

    a_r5_only_committed: assert property (@(posedge clk) disable iff (!rst_n)
        occ_cmt <= occ_all);

    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        occ_all <= (AW+1)'(DEPTH));

    a_r7_flush_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !in_ready);

    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !out_valid);

    a_r9_bad_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (set_stb && (set_addr == CFG_ADDR) && bad_size) |=> $stable(pend_n));

    a_r10_size_held_in_group: assert property (@(posedge clk) disable iff (!rst_n)
        ((grp_cnt != '0) && !(in_valid && in_ready && in_last) && !clear && !flush)
        |=> $stable(act_n));

    a_r11_output_held: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !clear)
        |=> (out_valid && $stable(out_data) && $stable(out_side) && $stable(out_last)));

endmodule

bind grp_drop_buf grp_drop_buf_chk #(
    .DATA_W   (DATA_W),
    .MAX_GRP  (MAX_GRP),
    .CFG_ADDR (CFG_ADDR),
    .AW       (AW),
    .CW       (CW)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .flush     (flush),
    .set_stb   (set_stb),
    .set_addr  (set_addr),
    .set_data  (set_data),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_last   (in_last),
    .out_data  (out_data),
    .out_side  (out_side),
    .out_last  (out_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .wr_ptr    (wr_ptr),
    .cmt_ptr   (cmt_ptr),
    .rd_ptr    (rd_ptr),
    .grp_cnt   (grp_cnt),
    .act_n     (act_n),
    .pend_n    (pend_n)
);

// File: tb/test_grp_drop_buf.sv
// Self-checking bench: a queue-based reference model runs on every
// negative clock edge and compares the output stream with the groups
// it expects to be committed.
module test_grp_drop_buf;

    localparam int unsigned DW   = 32;
    localparam int unsigned MAXG = 16;
    localparam logic [7:0]  CFG  = 8'h10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear = 1'b0;
    logic          flush = 1'b0;
    logic          set_stb = 1'b0;
    logic [7:0]    set_addr = '0;
    logic [31:0]   set_data = '0;
    logic [DW-1:0] in_data = '0;
    logic          in_side = 1'b0;
    logic          in_last = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] out_data;
    logic          out_side;
    logic          out_last;
    logic          out_valid;
    logic          out_ready = 1'b0;

    int            total = 0;
    int            bad = 0;
    int            rdy_mode = 0;
    int            acc_cnt = 0;
    int            cycles = 0;
    logic [31:0]   seq = 32'h100;
    string         cur_tag = "R2";

    logic [33:0]   exp_q[$];
    logic [33:0]   cur_q[$];
    int            act_m = 4;
    int            pend_m = 4;
    logic          prev_stall = 1'b0;
    logic [33:0]   prev_word = '0;
    logic [33:0]   got;
    logic [33:0]   exp_w;
    logic          fire;
    logic          empty0;

    grp_drop_buf #(
        .DATA_W   (DW),
        .MAX_GRP  (MAXG),
        .DEF_GRP  (4),
        .CFG_ADDR (CFG)
    ) i_grp_drop_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .flush     (flush),
        .set_stb   (set_stb),
        .set_addr  (set_addr),
        .set_data  (set_data),
        .in_data   (in_data),
        .in_side   (in_side),
        .in_last   (in_last),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .out_data  (out_data),
        .out_side  (out_side),
        .out_last  (out_last),
        .out_valid (out_valid),
        .out_ready (out_ready)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] actual, input logic [63:0] expected);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, actual, expected);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Output ready pattern: 0 low, 1 high, 2 random
    always @(posedge clk) begin
        #1;
        if (rdy_mode == 0)      out_ready = 1'b0;
        else if (rdy_mode == 1) out_ready = 1'b1;
        else                    out_ready = 1'($urandom_range(0, 1));
    end

    // Reference model, evaluated where all inputs and outputs are settled
    always @(negedge clk) begin
        if (!rst_n) begin
            exp_q.delete();
            cur_q.delete();
            act_m = 4;
            pend_m = 4;
            prev_stall = 1'b0;
        end else begin
            got    = {out_last, out_side, out_data};
            fire   = in_valid && in_ready;
            empty0 = (cur_q.size() == 0);
            if (prev_stall) begin
                chk(out_valid && (got == prev_word), "R11", "held output word",
                    64'(got), 64'(prev_word));
            end
            prev_stall = out_valid && !out_ready && !clear;
            prev_word  = got;
            if (flush || clear) begin
                chk(!in_ready, flush ? "R7" : "R8", "in_ready during flush/clear",
                    64'(in_ready), 64'd0);
            end
            if (clear) begin
                exp_q.delete();
                cur_q.delete();
                act_m = pend_m;
            end else begin
                if (out_valid && exp_q.size() == 0) begin
                    chk(1'b0, "R5", "out_valid with nothing committed", 64'd1, 64'd0);
                end else if (out_valid && out_ready) begin
                    exp_w = exp_q.pop_front();
                    chk(got[32:0] == exp_w[32:0], cur_tag, "output word",
                        64'(got[32:0]), 64'(exp_w[32:0]));
                    chk(got[33] == exp_w[33], "R12", "out_last",
                        64'(got[33]), 64'(exp_w[33]));
                end
                if (flush) begin
                    cur_q.delete();
                end else if (fire) begin
                    cur_q.push_back({1'b0, in_side, in_data});
                    acc_cnt++;
                    if (in_last) begin
                        if (cur_q.size() == act_m) begin
                            for (int i = 0; i < cur_q.size(); i++) begin
                                exp_q.push_back({(i == cur_q.size() - 1), cur_q[i][32:0]});
                            end
                        end
                        cur_q.delete();
                    end
                end
                if (flush || (fire && in_last) || (empty0 && !fire)) act_m = pend_m;
                if (set_stb && set_addr == CFG && set_data >= 1 && set_data <= MAXG) begin
                    pend_m = int'(set_data);
                end
            end
        end
    end

    task automatic push(input logic [31:0] d, input logic l, input int gap);
        repeat (gap) tick();
        in_data  = d;
        in_side  = d[0] ^ d[2];
        in_last  = l;
        in_valid = 1'b1;
        do @(negedge clk); while (!in_ready);
        tick();
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic send(input int len);
        for (int i = 0; i < len; i++) begin
            push(seq, (i == len - 1), $urandom_range(0, 2));
            seq++;
        end
    endtask

    task automatic set_wr(input logic [7:0] a, input logic [31:0] d);
        tick();
        set_stb  = 1'b1;
        set_addr = a;
        set_data = d;
        tick();
        set_stb  = 1'b0;
        repeat (2) tick();
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 3000; i++) begin
            tick();
            if (exp_q.size() == 0 && !out_valid) break;
        end
        @(negedge clk);
        chk(exp_q.size() == 0 && !out_valid, req, "all expected words delivered",
            64'(exp_q.size()), 64'd0);
    endtask

    // Watchdog: a hung run is a failed check and still reports
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog (all requirements) actual=%0d expected=%0d", cycles, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) tick();
        @(negedge clk);
        chk(!out_valid, "R1", "out_valid in reset", 64'(out_valid), 64'd0);
        tick();
        rst_n = 1'b1;
        tick();
        @(negedge clk);
        chk(!out_valid, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
        chk(in_ready, "R1", "in_ready after reset", 64'(in_ready), 64'd1);

        // R2: exact groups under random back-pressure (default size 4)
        rdy_mode = 2;
        cur_tag = "R2";
        send(4); send(4); send(4);
        drain("R2");

        // R3: short groups disappear, full groups around them survive
        cur_tag = "R3";
        send(2); send(4); send(1); send(3); send(4);
        drain("R3");

        // R4: over-long groups disappear
        cur_tag = "R4";
        send(6); send(4); send(5);
        drain("R4");

        // R5: partial group stays invisible until its last word
        cur_tag = "R5";
        rdy_mode = 1;
        for (int i = 0; i < 3; i++) begin
            push(seq, 1'b0, 0);
            seq++;
        end
        repeat (6) tick();
        @(negedge clk);
        chk(!out_valid, "R5", "no output before group completes", 64'(out_valid), 64'd0);
        push(seq, 1'b1, 0);
        seq++;
        drain("R5");

        // R9: only legal writes to the configured address take effect
        rdy_mode = 2;
        cur_tag = "R9";
        set_wr(CFG, 32'd3);
        set_wr(CFG, 32'd0);
        set_wr(CFG, 32'd17);
        set_wr(CFG + 8'd1, 32'd7);
        send(3); send(7); send(3); send(4);
        drain("R9");

        // R10: size change mid-group applies to the next group only
        cur_tag = "R10";
        push(seq, 1'b0, 0); seq++;
        push(seq, 1'b0, 0); seq++;
        set_wr(CFG, 32'd5);
        push(seq, 1'b1, 0); seq++;
        send(5); send(3); send(5);
        drain("R10");

        // R7: flush drops the partial group only
        cur_tag = "R7";
        set_wr(CFG, 32'd3);
        send(3);
        push(seq, 1'b0, 0); seq++;
        push(seq, 1'b0, 0); seq++;
        in_data  = seq;
        in_valid = 1'b1;
        flush    = 1'b1;
        repeat (2) tick();
        flush    = 1'b0;
        in_valid = 1'b0;
        send(3);
        drain("R7");

        // R6: fill storage with output stalled, size 4, 16 words of storage
        cur_tag = "R6";
        set_wr(CFG, 32'd4);
        rdy_mode = 0;
        acc_cnt  = 0;
        begin
            int idx;
            idx = 0;
            in_valid = 1'b1;
            for (int c = 0; c < 40; c++) begin
                in_data = seq + idx;
                in_side = in_data[0] ^ in_data[2];
                in_last = (idx % 4 == 3);
                @(negedge clk);
                if (in_ready) idx++;
                tick();
            end
            in_valid = 1'b0;
            in_last  = 1'b0;
            chk(acc_cnt == 17, "R6", "words accepted with output stalled",
                64'(acc_cnt), 64'd17);
            rdy_mode = 2;
            for (int k = 17; k < 20; k++) begin
                push(seq + k, (k == 19), 0);
            end
            seq = seq + 20;
        end
        drain("R6");

        // R8: clear drops committed and partial words, keeps pending size
        cur_tag = "R8";
        rdy_mode = 0;
        send(4); send(4);
        push(seq, 1'b0, 0); seq++;
        repeat (3) tick();
        clear = 1'b1;
        tick();
        clear = 1'b0;
        @(negedge clk);
        chk(!out_valid, "R8", "out_valid after clear", 64'(out_valid), 64'd0);
        rdy_mode = 2;
        send(4); send(2);
        drain("R8");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule